// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Row/Column Scan Driver

This block produces the time-multiplexed drive pattern for a character dot-matrix panel that has 16 row (common) lines and 40 column (segment) lines. A fixed row period of `ROW_CYC` clocks is repeated. In the first part of each period the block asks an upstream font stage for one dot per clock. The first `SEG_W` dots are shifted into a local column register. The next `EXT_DOTS` dots are forwarded, one per pulse of a shift strobe, to a cascaded column extension driver. On the last clock of the period the assembled row is copied into the column output latch. In the same clock edge the one-hot row selection moves to the next common line and a latch strobe goes to the extension driver.

The number of rows in one scan is picked among 8, 11 and 16. This matches a single text line in the short font, a single text line in the tall font, or two text lines. Rows beyond the chosen count are never driven. A polarity output flips once per complete scan, so that the panel sees an alternating (AC) waveform. The upstream font stage reads `load_row` to learn which row's dots it must supply.

Top module: `lcd_scan_drv`

## Requirements
- R1: While `rst_n` is low and until the first row latch, `seg`, `com`, `m_alt`, `ext_sclk`, `ext_dat` and `ext_lclk` are all 0, and `load_row` is 0.
- R2: A row period lasts exactly `ROW_CYC` clocks (96 by default). `dot_take` is high for the first `SEG_W + EXT_DOTS` clocks (80 by default) of every period, and low for the rest.
- R3: The dot sampled on the k-th `dot_take` clock of a period (k counted from 0, k < `SEG_W`) appears on `seg[k]` after that period's latch. `seg` changes only on the clock in which `ext_lclk` is high.
- R4: `com` is zero or one-hot. The first latch after reset selects `com[0]`. Each later latch moves the selection from `com[i]` to `com[i+1]`, except at the wrap.
- R5: `duty_sel` encoding: 2'b00 gives 8 rows, 2'b01 gives 11 rows, 2'b10 and 2'b11 give 16 rows. After the last active row the selection wraps to `com[0]`, and `com` bits at or above the row count stay 0. `duty_sel` takes effect only at the first latch and at each wrap.
- R6: `m_alt` toggles exactly at the latch that wraps the selection back to `com[0]`, and at no other time.
- R7: For dot k with `SEG_W` <= k < `SEG_W + EXT_DOTS`, `ext_sclk` is high for one clock, one clock after the dot was sampled, and `ext_dat` carries that dot. When `ext_sclk` is low, `ext_dat` is 0. There are exactly `EXT_DOTS` such pulses per period.
- R8: `ext_lclk` is a one-clock pulse once per period. It is high in the same clock in which the new `seg` and `com` values first appear.
- R9: `load_row` gives the 0-based index of the common line that the end-of-period latch will select. The data on `seg` during `com[r]` is the data loaded while `load_row` was r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| duty_sel | input | 2 | Row-count select (00: 8, 01: 11, 1x: 16) |
| dot_in | input | 1 | Serial dot from the font stage, sampled when `dot_take` is high |
| dot_take | output | 1 | Dot request/sample strobe |
| load_row | output | 4 | Row index whose dots are being loaded |
| seg | output | 40 | Latched column data, bit k = column k |
| com | output | 16 | One-hot common line select |
| m_alt | output | 1 | Frame polarity for AC drive |
| ext_sclk | output | 1 | Extension driver shift strobe |
| ext_lclk | output | 1 | Extension driver latch strobe |
| ext_dat | output | 1 | Extension driver serial dot |

## Verification
The bound checker watches the invariants on every cycle. These are: `com` is one-hot or zero; `seg` and `com` hold still outside the latch pulse; the latch pulse lasts one clock; `m_alt` moves only with a wrap to `com[0]`; the extension data is quiet between shift strobes, and each strobe follows a dot request. The bench scenarios show what needs a reference model. They check the 96/80 clock period shape, and that the column bits match the dots sent for each row index. They also check the scan length and wrap for each `duty_sel` code, that `duty_sel` changes are deferred to a frame boundary, and that the 40 overflow dots arrive on the extension line in order.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   typedef enum logic [1:0] {
      DUTY_SHORT = 2'b00,
      DUTY_TALL  = 2'b01,
      DUTY_FULL  = 2'b10,
      DUTY_ALT   = 2'b11
   } duty_e;

   // number of commons scanned for a duty code
   function automatic int unsigned duty_rows(input logic [1:0] sel,
                                             input int unsigned n_short,
                                             input int unsigned n_tall,
                                             input int unsigned n_full);
      case (duty_e'(sel))
         DUTY_SHORT: return n_short;
         DUTY_TALL:  return n_tall;
         default:    return n_full;
      endcase
   endfunction

endpackage

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
   parameter int SEG_W    = 40,
   parameter int EXT_DOTS = 40,
   parameter int ROW_CYC  = 96
) (
   input  logic clk,
   input  logic rst_n,
   output logic take,
   output logic loc_shift,
   output logic ext_shift,
   output logic row_end
);
   localparam int TOT = SEG_W + EXT_DOTS;
   localparam int CW  = $clog2(ROW_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (row_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CW'(1);
   end

   always_comb begin
      row_end   = (cnt_q == CW'(ROW_CYC - 1));
      take      = (cnt_q < CW'(TOT));
      loc_shift = (cnt_q < CW'(SEG_W));
      ext_shift = take && !loc_shift;
   end

endmodule

// File: rtl/lcd_seg_path.sv
module lcd_seg_path #(
   parameter int SEG_W    = 40,
   parameter int EXT_DOTS = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dot_in,
   input  logic             loc_shift,
   input  logic             ext_shift,
   input  logic             row_end,
   output logic [SEG_W-1:0] seg,
   output logic             ext_sclk,
   output logic             ext_dat,
   output logic             ext_lclk
);
   logic [SEG_W-1:0] shift_q;
   logic [SEG_W-1:0] latch_q;
   logic             lclk_q;

   // first dot of a row ends up in bit 0 after SEG_W shifts
   always_ff @(posedge clk) begin
      if (!rst_n)
         shift_q <= '0;
      else if (loc_shift)
         shift_q <= {dot_in, shift_q[SEG_W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         lclk_q  <= 1'b0;
      end else begin
         lclk_q <= row_end;
         if (row_end)
            latch_q <= shift_q;
      end
   end

   generate
      if (EXT_DOTS > 0) begin : g_ext
         logic sclk_q;
         logic dat_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sclk_q <= 1'b0;
               dat_q  <= 1'b0;
            end else begin
               sclk_q <= ext_shift;
               dat_q  <= ext_shift & dot_in;
            end
         end
         assign ext_sclk = sclk_q;
         assign ext_dat  = dat_q;
      end else begin : g_no_ext
         logic unused_ext;
         assign unused_ext = ext_shift;
         assign ext_sclk   = 1'b0;
         assign ext_dat    = 1'b0;
      end
   endgenerate

   assign seg      = latch_q;
   assign ext_lclk = lclk_q;

endmodule

// File: rtl/lcd_com_ring.sv
module lcd_com_ring
   import lcd_scan_pkg::*;
#(
   parameter int COM_N   = 16,
   parameter int DUTY_S  = 8,
   parameter int DUTY_T  = 11,
   parameter int RW      = $clog2(COM_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             row_end,
   input  logic [1:0]       duty_sel,
   output logic [COM_N-1:0] com,
   output logic [RW-1:0]    load_row,
   output logic             m_alt
);
   localparam int CNW = $clog2(COM_N + 1);

   logic [COM_N-1:0] com_q;
   logic [CNW-1:0]   active_q;
   logic [CNW-1:0]   sel_cnt;
   logic [CNW-1:0]   act_use;
   logic [RW-1:0]    row_q;
   logic             m_q;
   logic             started;
   logic             at_end;
   logic             wrap_now;

   assign sel_cnt = CNW'(duty_rows(duty_sel, DUTY_S, DUTY_T, COM_N));
   assign started = |com_q;

   // selection sits on the last active common (or beyond, defensively)
   always_comb begin
      at_end = 1'b0;
      for (int i = 0; i < COM_N; i++) begin
         if (com_q[i] && (CNW'(i) >= active_q - CNW'(1)))
            at_end = 1'b1;
      end
   end

   assign wrap_now = !started || at_end;
   assign act_use  = wrap_now ? sel_cnt : active_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         com_q    <= '0;
         active_q <= CNW'(COM_N);
         row_q    <= '0;
         m_q      <= 1'b0;
      end else if (row_end) begin
         if (wrap_now) begin
            com_q    <= COM_N'(1);
            active_q <= sel_cnt;
            if (started)
               m_q <= ~m_q;
         end else begin
            com_q <= com_q << 1;
         end
         if ((CNW'(row_q) + CNW'(1)) >= act_use)
            row_q <= '0;
         else
            row_q <= row_q + RW'(1);
      end
   end

   assign com      = com_q;
   assign load_row = row_q;
   assign m_alt    = m_q;

endmodule

// File: rtl/lcd_scan_drv.sv
module lcd_scan_drv #(
   parameter int SEG_W    = 40,
   parameter int COM_N    = 16,
   parameter int EXT_DOTS = 40,
   parameter int ROW_CYC  = 96,
   parameter int DUTY_S   = 8,
   parameter int DUTY_T   = 11,
   parameter int RW       = $clog2(COM_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       duty_sel,
   input  logic             dot_in,
   output logic             dot_take,
   output logic [RW-1:0]    load_row,
   output logic [SEG_W-1:0] seg,
   output logic [COM_N-1:0] com,
   output logic             m_alt,
   output logic             ext_sclk,
   output logic             ext_lclk,
   output logic             ext_dat
);
   generate
      if (ROW_CYC <= SEG_W + EXT_DOTS) begin : g_bad_period
         $error("ROW_CYC must exceed SEG_W + EXT_DOTS");
      end
      if (DUTY_S < 2 || DUTY_S > DUTY_T || DUTY_T > COM_N) begin : g_bad_duty
         $error("duty counts must satisfy 2 <= DUTY_S <= DUTY_T <= COM_N");
      end
      if (SEG_W < 2) begin : g_bad_seg
         $error("SEG_W must be at least 2");
      end
   endgenerate

   logic loc_shift;
   logic ext_shift;
   logic row_end;

   lcd_scan_timing #(
      .SEG_W(SEG_W), .EXT_DOTS(EXT_DOTS), .ROW_CYC(ROW_CYC)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .take(dot_take),
      .loc_shift(loc_shift), .ext_shift(ext_shift), .row_end(row_end)
   );

   lcd_seg_path #(
      .SEG_W(SEG_W), .EXT_DOTS(EXT_DOTS)
   ) u_seg (
      .clk(clk), .rst_n(rst_n), .dot_in(dot_in),
      .loc_shift(loc_shift), .ext_shift(ext_shift), .row_end(row_end),
      .seg(seg), .ext_sclk(ext_sclk), .ext_dat(ext_dat), .ext_lclk(ext_lclk)
   );

   lcd_com_ring #(
      .COM_N(COM_N), .DUTY_S(DUTY_S), .DUTY_T(DUTY_T), .RW(RW)
   ) u_com (
      .clk(clk), .rst_n(rst_n), .row_end(row_end), .duty_sel(duty_sel),
      .com(com), .load_row(load_row), .m_alt(m_alt)
   );

endmodule

// File: rtl/lcd_scan_drv_chk.sv
module lcd_scan_drv_chk #(
   parameter int SEG_W = 40,
   parameter int COM_N = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dot_take,
   input logic [SEG_W-1:0] seg,
   input logic [COM_N-1:0] com,
   input logic             m_alt,
   input logic             ext_sclk,
   input logic             ext_lclk,
   input logic             ext_dat
);
   p_com_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(com));

   p_seg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_lclk |-> ($stable(seg) && $stable(com)));

   p_lclk_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_lclk |=> !ext_lclk);

   p_m_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(m_alt) |-> (ext_lclk && com[0]));

   p_sclk_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_sclk |-> $past(dot_take));

   p_dat_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_sclk |-> !ext_dat);

endmodule

bind lcd_scan_drv lcd_scan_drv_chk #(.SEG_W(SEG_W), .COM_N(COM_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .dot_take(dot_take), .seg(seg), .com(com),
   .m_alt(m_alt), .ext_sclk(ext_sclk), .ext_lclk(ext_lclk), .ext_dat(ext_dat)
);

// File: tb/lcd_scan_drv_bench.sv
module lcd_scan_drv_bench;
   localparam int SEG_W    = 40;
   localparam int COM_N    = 16;
   localparam int EXT_DOTS = 40;
   localparam int ROW_CYC  = 96;
   localparam int RW       = $clog2(COM_N);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       duty_sel = 2'b10;
   logic             dot_in = 1'b0;
   logic             dot_take;
   logic [RW-1:0]    load_row;
   logic [SEG_W-1:0] seg;
   logic [COM_N-1:0] com;
   logic             m_alt, ext_sclk, ext_lclk, ext_dat;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   lcd_scan_drv u_lcd_scan_drv (
      .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .dot_in(dot_in),
      .dot_take(dot_take), .load_row(load_row), .seg(seg), .com(com),
      .m_alt(m_alt), .ext_sclk(ext_sclk), .ext_lclk(ext_lclk), .ext_dat(ext_dat)
   );

   function automatic logic pat(input int r, input int k);
      return ((r * 3 + k * 5 + (k >> 3)) % 7) < 3;
   endfunction

   function automatic logic [SEG_W-1:0] row_vec(input int r);
      logic [SEG_W-1:0] v;
      for (int k = 0; k < SEG_W; k++) v[k] = pat(r, k);
      return v;
   endfunction

   task automatic check(input string req, input logic ok, input string what,
                        input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   // dot source: supplies the pattern bit for the requested row and position
   initial begin
      int k = 0;
      forever begin
         @(negedge clk);
         if (rst_n && dot_take) begin
            dot_in = pat(int'(load_row), k);
            k++;
         end else begin
            k = 0;
            dot_in = 1'b0;
         end
      end
   end

   task automatic wait_lclk();
      do @(negedge clk); while (!ext_lclk);
   endtask

   task automatic wait_wrap();
      do wait_lclk(); while (!com[0]);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1", seg == '0 && com == '0, "seg/com in reset", {seg[7:0], com}, 0);
      check("R1", !m_alt && !ext_sclk && !ext_dat && !ext_lclk && load_row == '0,
            "strobes in reset", {m_alt, ext_sclk, ext_dat, ext_lclk}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check("R1", com == '0 && seg == '0, "before first latch", com, 0);
   endtask

   task automatic t_window();
      int takes = 0;
      int len = 0;
      wait_lclk();
      do begin
         if (dot_take) takes++;
         len++;
         @(negedge clk);
      end while (!ext_lclk);
      check("R2", len == ROW_CYC, "row period length", len, ROW_CYC);
      check("R2", takes == SEG_W + EXT_DOTS, "dot requests per row", takes, SEG_W + EXT_DOTS);
   endtask

   task automatic t_ext();
      int row;
      int cnt = 0;
      int bad = 0;
      wait_lclk();
      row = int'(load_row);
      do begin
         @(negedge clk);
         if (ext_sclk) begin
            if (ext_dat !== pat(row, SEG_W + cnt)) bad++;
            cnt++;
         end
      end while (!ext_lclk);
      check("R7", cnt == EXT_DOTS, "extension shift count", cnt, EXT_DOTS);
      check("R7", bad == 0, "extension dot mismatches", bad, 0);
   endtask

   task automatic run_frame(input logic [1:0] dsel, input int nrow, input string tag);
      logic m0;
      duty_sel = dsel;
      wait_wrap();
      wait_wrap();
      m0 = m_alt;
      for (int r = 0; r < nrow; r++) begin
         check("R4", com == (COM_N'(1) << r), {tag, " common select"}, com, COM_N'(1) << r);
         check("R9", seg == row_vec(r), {tag, " row data on seg"}, seg, row_vec(r));
         if (r > 0) check("R6", m_alt == m0, {tag, " polarity mid-frame"}, m_alt, m0);
         wait_lclk();
      end
      check("R5", com == COM_N'(1), {tag, " wrap to first common"}, com, 1);
      check("R6", m_alt == !m0, {tag, " polarity at wrap"}, m_alt, !m0);
   endtask

   task automatic t_deferred();
      // change duty in mid-frame: the running frame keeps its length
      duty_sel = 2'b10;
      wait_wrap();
      wait_wrap();
      repeat (3) wait_lclk();
      duty_sel = 2'b00;
      for (int r = 3; r < 16; r++) wait_lclk();
      check("R5", com == COM_N'(1), "deferred duty: 16-row frame completes", com, 1);
      for (int r = 0; r < 8; r++) wait_lclk();
      check("R5", com == COM_N'(1), "new 8-row frame after wrap", com, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_window();
      t_ext();
      run_frame(2'b00, 8, "duty8");
      run_frame(2'b01, 11, "duty11");
      run_frame(2'b10, 16, "duty16");
      run_frame(2'b11, 16, "duty16b");
      t_deferred();
      summary();
      $finish;
   end

endmodule